// File: doc/BRIEF.md
# Serial Control Port Register Slave

This block gives a host microprocessor byte-wide access to a bank of 8-bit control registers over a four-wire serial link. The link has a serial clock, an active-low chip select, serial data in and serial data out. All of these signals are sampled by the block's own system clock. A transaction opens when chip select falls. The first byte shifted in is a command byte, which carries a read/write flag and a 5-bit register address.

Every later byte in the same chip-select window is data for that one address. In a write window, each complete data byte updates the register and raises a one-cycle write strobe, which the rest of the chip can observe. In a read window, the addressed register is shifted out on every data byte. To issue a new command, the host must raise chip select and lower it again.

The registers are held inside the block and are presented on a flat output bus. Register n occupies bits 8n+7 down to 8n. The serial clock must stay in each level for at least SYNC_STAGES+2 system clocks.

Top module: `ctl_port_slave`

## Requirements
- R1: After reset every register reads 0x00, wr_stb_o is low, sdo_oe_o is low and sdo_o is low.
- R2: The first byte after chip select falls is the command, shifted in MSB first on rising serial-clock edges. Bit 6 set means read. Bits 4..0 are the address. Bits 7 and 5 have no effect.
- R3: In a write window, each complete data byte pulses wr_stb_o for exactly one system clock, with wr_addr_o and wr_data_o holding the address and the byte. regs_o shows the new value on the following clock.
- R4: All data bytes in one window use the command's address. A data byte whose value looks like a command is still written as data.
- R5: In a read window, the register value captured at the end of the command byte, and again at the end of each data byte, is driven MSB first on sdo_o after falling serial-clock edges. This makes it valid for the host to sample on the next rising edge. Reads change no register.
- R6: If chip select rises before the eighth bit of a byte, that byte is discarded. There is no strobe and no register change, and the next window starts again with a command byte.
- R7: sdo_oe_o is low while chip select is inactive and high inside a window, and sdo_o is low whenever sdo_oe_o is low.
- R8: Addresses at or above NUM_REGS read as 0x00, and writes to them produce no strobe and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| cs_ni | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for sdo_o; the pad is high-impedance when this is low |
| wr_stb_o | output | 1 | One-cycle strobe per written byte |
| wr_addr_o | output | 5 | Address of the write |
| wr_data_o | output | 8 | Data of the write |
| regs_o | output | NUM_REGS*8 | Register bank contents, register n at bits 8n+7..8n |

## Verification
The bench builds the block with NUM_REGS=24 and SYNC_STAGES=2. The smaller bank puts addresses 24 to 31 inside the 5-bit field, so reads returning zero and writes being suppressed for those addresses are exercised by both directed and random windows. The two-stage synchronizer, together with a host half-period of six system clocks, sets the margin between edge detection and the data-out update that R5 relies on.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int RW_BIT = 6;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/ctl_port_sync.sv
module ctl_port_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= {STAGES{RST_VAL}};
    else         pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ctl_port_regfile.sv
module ctl_port_regfile
  import ctl_port_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= '0;
      else if (we_i && waddr_i == ADDR_W'(g))      mem[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

  // Unmapped addresses fall through to zero.
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = mem[i];
  end
endmodule

// File: rtl/ctl_port_frame.sv
module ctl_port_frame
  import ctl_port_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic              sclk_d;
  logic              sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  phase_e            phase;
  logic [DATA_W-2:0] rx;
  logic [DATA_W-1:0] byte_in;
  logic [DATA_W-1:0] tx;
  logic              rd_mode;
  logic              load_pend;
  logic [ADDR_W-1:0] addr;
  logic              in_range;
  logic              last_bit;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign sclk_fall = ~sclk_i & sclk_d;
  assign byte_in   = {rx, sdi_i};
  assign in_range  = int'(addr) < NUM_REGS;
  assign last_bit  = bit_cnt == CNT_W'(DATA_W-1);
  assign addr_o    = addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b0;
      bit_cnt   <= '0;
      phase     <= PH_CMD;
      rx        <= '0;
      tx        <= '0;
      rd_mode   <= 1'b0;
      load_pend <= 1'b0;
      addr      <= '0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
    end else begin
      sclk_d   <= sclk_i;
      wr_stb_o <= 1'b0;
      if (!cs_act_i) begin
        // Idle or aborted window: drop any partial byte.
        bit_cnt   <= '0;
        phase     <= PH_CMD;
        rx        <= '0;
        tx        <= '0;
        rd_mode   <= 1'b0;
        load_pend <= 1'b0;
        sdo_o     <= 1'b0;
        sdo_oe_o  <= 1'b0;
      end else begin
        sdo_oe_o <= 1'b1;
        if (load_pend) begin
          tx        <= rd_data_i;
          load_pend <= 1'b0;
        end
        if (sclk_rise) begin
          rx      <= byte_in[DATA_W-2:0];
          bit_cnt <= bit_cnt + CNT_W'(1);
          if (last_bit) begin
            if (phase == PH_CMD) begin
              phase     <= PH_DATA;
              rd_mode   <= byte_in[RW_BIT];
              addr      <= byte_in[ADDR_W-1:0];
              load_pend <= byte_in[RW_BIT];
            end else if (rd_mode) begin
              load_pend <= 1'b1;
            end else if (in_range) begin
              wr_stb_o  <= 1'b1;
              wr_data_o <= byte_in;
            end
          end
        end
        if (sclk_fall) begin
          if (phase == PH_DATA && rd_mode) begin
            sdo_o <= tx[DATA_W-1];
            tx    <= {tx[DATA_W-2:0], 1'b0};
          end else begin
            sdo_o <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctl_port_slave.sv
module ctl_port_slave
  import ctl_port_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic                       wr_stb_o,
  output logic [ADDR_W-1:0]          wr_addr_o,
  output logic [DATA_W-1:0]          wr_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  localparam int         N_SYNC   = 3;
  localparam logic [2:0] SYNC_RST = 3'b010; // {sdi, cs_n, sclk}

  logic [N_SYNC-1:0] raw_in, sync_q;
  logic              cs_act;
  logic [DATA_W-1:0] rd_data;

  assign raw_in = {sdi_i, cs_ni, sclk_i};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    ctl_port_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST[g])
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_in[g]),
      .q_o   (sync_q[g])
    );
  end

  assign cs_act = ~sync_q[1];

  ctl_port_frame #(.NUM_REGS(NUM_REGS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .sclk_i   (sync_q[0]),
    .sdi_i    (sync_q[2]),
    .rd_data_i(rd_data),
    .addr_o   (wr_addr_o),
    .wr_stb_o (wr_stb_o),
    .wr_data_o(wr_data_o),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
  );

  ctl_port_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_stb_o),
    .waddr_i(wr_addr_o),
    .wdata_i(wr_data_o),
    .raddr_i(wr_addr_o),
    .rdata_o(rd_data),
    .regs_o (regs_o)
  );
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk
  import ctl_port_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cs_act_i,
  input logic                       wr_stb_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic [NUM_REGS*DATA_W-1:0] regs_i,
  input logic                       sdo_i,
  input logic                       sdo_oe_i
);
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_addr <= wr_addr_i;
      last_data <= wr_data_i;
    end
  end

  p_stb_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !wr_stb_i);

  p_reg_written_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> regs_i[int'(last_addr)*DATA_W +: DATA_W] == last_data);

  p_regs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(regs_i));

  p_stb_in_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> $past(cs_act_i));

  p_oe_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !sdo_oe_i);

  p_sdo_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_i |-> !sdo_i);

  p_stb_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> int'(wr_addr_i) < NUM_REGS);
endmodule

bind ctl_port_slave ctl_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_act_i (cs_act),
  .wr_stb_i (wr_stb_o),
  .wr_addr_i(wr_addr_o),
  .wr_data_i(wr_data_o),
  .regs_i   (regs_o),
  .sdo_i    (sdo_o),
  .sdo_oe_i (sdo_oe_o)
);

// File: tb/tb_ctl_port_slave.sv
module tb_ctl_port_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS      = 24;
  localparam int HP         = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, wr_stb;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [NREGS*8-1:0] regs;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic [7:0] mdl [32];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_port_slave #(.NUM_REGS(NREGS), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .regs_o(regs)
  );

  always @(posedge clk) if (rst_n && wr_stb) stb_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    return (int'(a) < NREGS) ? mdl[a] : 8'h00;
  endfunction

  function automatic int reg_mismatch();
    int n = 0;
    for (int i = 0; i < NREGS; i++) if (regs[i*8 +: 8] != mdl[i]) n++;
    return n;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = b[i];
      wait_clk(HP);
      sclk = 1'b1;
      got[i] = sdo;
      wait_clk(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_high();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  // Full window: command plus n data bytes from wbuf, read bytes into rbuf.
  task automatic txn(input logic [7:0] cmd, input int n);
    logic [7:0] g;
    cs_low();
    send_bits(cmd, 8, g);
    for (int k = 0; k < n; k++) begin
      send_bits(wbuf[k], 8, g);
      rbuf[k] = g;
    end
    cs_high();
  endtask

  task automatic model_txn(input logic [7:0] cmd, input int n, input string req);
    int s0 = stb_cnt;
    logic [4:0] a = cmd[4:0];
    bit rd = cmd[6];
    txn(cmd, n);
    if (rd) begin
      for (int k = 0; k < n; k++) check({req, " read byte"}, int'(rbuf[k]), int'(exp_rd(a)));
      check({req, " read strobes"}, stb_cnt - s0, 0);
    end else begin
      if (int'(a) < NREGS) mdl[a] = wbuf[n-1];
      check({req, " write strobes"}, stb_cnt - s0, (int'(a) < NREGS) ? n : 0);
    end
    check({req, " bank"}, reg_mismatch(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] g;
    int s0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 bank zero", reg_mismatch(), 0);
    check("R1 strobe", int'(wr_stb), 0);
    check("R1 oe", int'(sdo_oe), 0);
    check("R1 sdo", int'(sdo), 0);
    model_txn(8'h45, 1, "R1 R5 initial read");

    // R3 basic write, R2 ignored bits 7/5
    wbuf[0] = 8'h3C; model_txn(8'h02, 1, "R3 write");
    wbuf[0] = 8'h5A; model_txn(8'hA7, 1, "R2 ignored bits write");
    model_txn(8'h42, 1, "R5 read");
    model_txn(8'hE7, 1, "R2 ignored bits read");
    check("R2 reg7", int'(regs[7*8 +: 8]), 'h5A);

    // R4 burst and command look-alike
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    model_txn(8'h09, 3, "R4 burst write");
    check("R4 reg9 last", int'(regs[9*8 +: 8]), 'h33);
    wbuf[0] = 8'h11; wbuf[1] = 8'h4A;
    model_txn(8'h0A, 2, "R4 look-alike");
    check("R4 reg10", int'(regs[10*8 +: 8]), 'h4A);
    check("R4 reg11 untouched", int'(regs[11*8 +: 8]), 0);
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
    model_txn(8'h49, 3, "R4 R5 burst read");

    // R7 output enable inside and outside a window
    cs_low();
    check("R7 oe in window", int'(sdo_oe), 1);
    send_bits(8'h42, 8, g);
    send_bits(8'h00, 8, g);
    check("R5 read in R7 window", int'(g), 'h3C);
    cs_high();
    check("R7 oe idle", int'(sdo_oe), 0);
    check("R7 sdo idle", int'(sdo), 0);

    // R6 aborted data byte and aborted command byte
    s0 = stb_cnt;
    cs_low(); send_bits(8'h02, 8, g); send_bits(8'hFF, 4, g); cs_high();
    check("R6 abort data strobes", stb_cnt - s0, 0);
    check("R6 abort data bank", reg_mismatch(), 0);
    cs_low(); send_bits(8'h43, 3, g); cs_high();
    wbuf[0] = 8'h77; model_txn(8'h03, 1, "R6 after aborted command");

    // R8 out of range
    wbuf[0] = 8'hEE; model_txn(8'h1C, 1, "R8 write high");
    model_txn(8'h5C, 1, "R8 read high");
    wbuf[0] = 8'h81; model_txn(8'h17, 1, "R8 top in-range");

    // Random windows
    for (int t = 0; t < 40; t++) begin
      logic [7:0] cmd;
      int n;
      cmd = 8'($urandom());
      n = 1 + int'($urandom() % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
      model_txn(cmd, n, "R2 R3 R4 R5 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule